// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block sits between a host processor bus and a two-channel UART register file. One strap input chooses between two bus styles that share the same pins. In split-strobe style there are separate active-low read and write strobes and one active-low select for each channel. In combined style a single read/write line replaces the write strobe, the read strobe is ignored, the first select pin becomes the device select, and the second select pin becomes a channel address bit.

Three address bits pick one of eight byte registers inside the chosen channel. Each channel's registers are a plain storage stub whose register at index 4 is the modem-control byte. The data bus is modelled as a driven value plus an output enable. The interrupt pins also follow the strap. In split-strobe style each channel has its own interrupt pin, which is driven only while bit 3 of that channel's modem-control byte is set. In combined style the channel-0 interrupt pin becomes one shared active-low open-drain request.

All strobes and selects are brought into the core clock through synchronisers and then edge-detected. A write therefore lands a few core cycles after the releasing edge.

Top module: `dual_bus_front`

## Requirements
- R1: After reset all sixteen stub registers read as zero, `data_oe` is 0, both `irq_oe` bits are 0 and both `op2_n` bits are 1.
- R2: With `mode_split`=1, a low-then-high pulse on `wr_n` while `sel0_n` is low (channel 0) or `sel1_n` is low (channel 1) stores `data_in` into register `addr` of that channel when `wr_n` rises.
- R3: With `mode_split`=1, while `rd_n` and one select are low, `data_oe` is 1 and `data_out` holds register `addr` of the selected channel. After the strobe is released `data_oe` returns to 0.
- R4: With `mode_split`=1 and both selects high, a write pulse changes no register and a read strobe does not drive the bus.
- R5: With `mode_split`=0, a write occurs when `sel0_n` rises while `wr_n` is low (write). `sel1_n` picks the channel: 0 selects channel 0 and 1 selects channel 1.
- R6: With `mode_split`=0, the bus is driven with the addressed register whenever `sel0_n` is low and `wr_n` is high (read), whatever the level of `rd_n`.
- R7: With `mode_split`=1, channel k's `irq_oe[k]` equals bit 3 of its modem-control register (index 4), `irq_o[k]` follows `irq_req[k]`, and `op2_n[k]` is the inverse of that bit.
- R8: With `mode_split`=0, `irq_oe[0]` is 1 and `irq_o[0]` is 0 exactly when either bit of `irq_req` is set, and `irq_oe[1]` is 0.
- R9: The eight registers of each channel are independent: a write to one address and one channel leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_split | input | 1 | Bus style strap: 1 selects split strobes, 0 selects combined read/write |
| addr | input | 3 | Register index within the channel |
| data_in | input | 8 | Bus byte from the host |
| data_out | output | 8 | Bus byte to the host |
| data_oe | output | 1 | Enable for driving the data bus |
| rd_n | input | 1 | Read strobe, active low. Ignored in combined style |
| wr_n | input | 1 | Write strobe (split) or read/write line, 1 meaning read (combined) |
| sel0_n | input | 1 | Channel-0 select (split) or device select (combined), active low |
| sel1_n | input | 1 | Channel-1 select (split) or channel address bit (combined) |
| irq_req | input | 2 | Pending interrupt request from each channel's engine |
| irq_o | output | 2 | Interrupt pin values |
| irq_oe | output | 2 | Interrupt pin drive enables (open drain in combined style) |
| op2_n | output | 2 | Per-channel general output, the inverse of modem-control bit 3 |

## Verification
The assertions assume that the mode strap stays fixed while any transaction is in progress. They also assume that address, data, the read/write level and the channel bit are stable around every releasing edge, and that both channel selects are never low together in split-strobe style. Each bench transaction first settles address and data. It then asserts a select, holds each strobe for several core cycles, releases the committing edge before anything else, and only then returns the bus to idle. Random choices are limited to channel, address, data and the ignored read strobe.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
   typedef enum logic {
      BUS_COMBINED = 1'b0,
      BUS_SPLIT    = 1'b1
   } bus_style_e;

   typedef struct packed {
      logic rd_n;
      logic wr_n;
      logic sel0_n;
      logic sel1_n;
   } bus_pins_t;

   localparam int unsigned PIN_COUNT = 4;
endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dbf_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dbf_decode.sv
module dbf_decode
   import dbf_pkg::*;
#(
   parameter int unsigned NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_style_e        style,
   input  bus_pins_t         pins,
   output logic [NUM_CH-1:0] wr_en,
   output logic              rd_en,
   output logic              rd_ch
);
   if (NUM_CH != 2) begin : g_bad_ch
      $error("dbf_decode: exactly two channels are decoded");
   end

   logic wr_n_q;
   logic sel0_n_q;
   logic wr_rise;
   logic sel0_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_n_q   <= 1'b1;
         sel0_n_q <= 1'b1;
      end else begin
         wr_n_q   <= pins.wr_n;
         sel0_n_q <= pins.sel0_n;
      end
   end

   assign wr_rise   = pins.wr_n & ~wr_n_q;
   assign sel0_rise = pins.sel0_n & ~sel0_n_q;

   always_comb begin
      wr_en = '0;
      rd_en = 1'b0;
      rd_ch = 1'b0;
      if (style == BUS_SPLIT) begin
         wr_en[0] = wr_rise & ~pins.sel0_n;
         wr_en[1] = wr_rise & ~pins.sel1_n;
         rd_en    = ~pins.rd_n & (~pins.sel0_n | ~pins.sel1_n);
         rd_ch    = pins.sel0_n;
      end else begin
         wr_en[0] = sel0_rise & ~pins.wr_n & ~pins.sel1_n;
         wr_en[1] = sel0_rise & ~pins.wr_n &  pins.sel1_n;
         rd_en    = ~pins.sel0_n & pins.wr_n;
         rd_ch    = pins.sel1_n;
      end
   end

   // R2: a split-style write follows a low write strobe one cycle earlier
   a_r2_commit_on_strobe_release: assert property (@(posedge clk) disable iff (!rst_n)
      (style == BUS_SPLIT && |wr_en) |-> ($past(pins.wr_n) == 1'b0));

   // R5: a combined-style write follows a low device select one cycle earlier
   a_r5_commit_on_select_release: assert property (@(posedge clk) disable iff (!rst_n)
      (style == BUS_COMBINED && |wr_en) |-> ($past(pins.sel0_n) == 1'b0));
endmodule

// File: rtl/dbf_regbank.sv
module dbf_regbank #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned MCR_IDX  = 4,
   parameter int unsigned GATE_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              gate
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (MCR_IDX >= DEPTH) begin : g_bad_idx
      $error("dbf_regbank: MCR_IDX outside register range");
   end
   if (GATE_BIT >= DATA_W) begin : g_bad_bit
      $error("dbf_regbank: GATE_BIT outside register width");
   end

   logic [DATA_W-1:0] regs [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     regs[i] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(i))        regs[i] <= wr_data;
      end
   end

   assign rd_data = regs[rd_addr];
   assign gate    = regs[MCR_IDX][GATE_BIT];

   // R2: a committed write is visible at its address on the next cycle
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (regs[$past(wr_addr)] == $past(wr_data)));

   // R9: a register not addressed by a write keeps its value
   a_r9_mcr_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_addr != ADDR_W'(MCR_IDX)) |=> $stable(regs[MCR_IDX]));
endmodule

// File: rtl/dbf_irq.sv
module dbf_irq
   import dbf_pkg::*;
#(
   parameter int unsigned NUM_CH = 2
) (
   input  bus_style_e        style,
   input  logic [NUM_CH-1:0] gate,
   input  logic [NUM_CH-1:0] req,
   output logic [NUM_CH-1:0] irq_o,
   output logic [NUM_CH-1:0] irq_oe,
   output logic [NUM_CH-1:0] op2_n
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (c == 0) begin : g_shared
         always_comb begin
            if (style == BUS_SPLIT) begin
               irq_o[c]  = req[c];
               irq_oe[c] = gate[c];
            end else begin
               irq_o[c]  = 1'b0;
               irq_oe[c] = |req;
            end
         end
      end else begin : g_own
         always_comb begin
            irq_o[c]  = (style == BUS_SPLIT) ? req[c]  : 1'b0;
            irq_oe[c] = (style == BUS_SPLIT) ? gate[c] : 1'b0;
         end
      end
      assign op2_n[c] = ~gate[c];
   end
endmodule

// File: rtl/dual_bus_front.sv
module dual_bus_front
   import dbf_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MCR_IDX     = 4,
   parameter int unsigned GATE_BIT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_split,
   input  logic [2:0]        addr,
   input  logic [7:0]        data_in,
   output logic [7:0]        data_out,
   output logic              data_oe,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              sel0_n,
   input  logic              sel1_n,
   input  logic [1:0]        irq_req,
   output logic [1:0]        irq_o,
   output logic [1:0]        irq_oe,
   output logic [1:0]        op2_n
);
   if (NUM_CH != 2) begin : g_bad_ch
      $error("dual_bus_front: NUM_CH must be 2");
   end
   if (DATA_W != 8 || ADDR_W != 3) begin : g_bad_bus
      $error("dual_bus_front: port widths fixed at 8 data and 3 address bits");
   end

   bus_style_e        style;
   bus_pins_t         raw_pins;
   bus_pins_t         pins_s;
   logic [NUM_CH-1:0] wr_en;
   logic              rd_en;
   logic              rd_ch;
   logic [NUM_CH-1:0] gate;
   logic [DATA_W-1:0] rd_data [NUM_CH];

   assign style    = bus_style_e'(mode_split);
   assign raw_pins = '{rd_n: rd_n, wr_n: wr_n, sel0_n: sel0_n, sel1_n: sel1_n};

   dbf_sync #(
      .WIDTH   (PIN_COUNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({PIN_COUNT{1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_pins),
      .q     (pins_s)
   );

   dbf_decode #(.NUM_CH(NUM_CH)) u_decode (
      .clk   (clk),
      .rst_n (rst_n),
      .style (style),
      .pins  (pins_s),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .rd_ch (rd_ch)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
      dbf_regbank #(
         .DATA_W   (DATA_W),
         .ADDR_W   (ADDR_W),
         .MCR_IDX  (MCR_IDX),
         .GATE_BIT (GATE_BIT)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en[c]),
         .wr_addr (addr),
         .wr_data (data_in),
         .rd_addr (addr),
         .rd_data (rd_data[c]),
         .gate    (gate[c])
      );
   end

   assign data_oe  = rd_en;
   assign data_out = rd_en ? rd_data[rd_ch] : '0;

   dbf_irq #(.NUM_CH(NUM_CH)) u_irq (
      .style  (style),
      .gate   (gate),
      .req    (irq_req),
      .irq_o  (irq_o),
      .irq_oe (irq_oe),
      .op2_n  (op2_n)
   );

   // R2: at most one channel is written in any cycle
   a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));

   // R4: the bus is driven only while a select is active
   a_r4_drive_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (!pins_s.sel0_n || (style == BUS_SPLIT && !pins_s.sel1_n)));

   // R3: no bus drive in a cycle that commits a write
   a_r3_no_drive_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_en) |-> !data_oe);
endmodule

// File: tb/dual_bus_front_bench.sv
module dual_bus_front_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_split = 1'b1;
   logic [2:0] addr = '0;
   logic [7:0] data_in = '0;
   logic [7:0] data_out;
   logic       data_oe;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic       sel0_n = 1'b1;
   logic       sel1_n = 1'b1;
   logic [1:0] irq_req = '0;
   logic [1:0] irq_o;
   logic [1:0] irq_oe;
   logic [1:0] op2_n;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [7:0] model [2][8];

   always #2 clk = ~clk;

   dual_bus_front u_dual_bus_front (
      .clk, .rst_n, .mode_split, .addr, .data_in, .data_out, .data_oe,
      .rd_n, .wr_n, .sel0_n, .sel1_n, .irq_req, .irq_o, .irq_oe, .op2_n
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [1:0] exp_oe(input logic split, input logic [1:0] req);
      logic [1:0] g;
      g = {model[1][4][3], model[0][4][3]};
      if (split) return g;
      return {1'b0, |req};
   endfunction

   function automatic logic [1:0] exp_o(input logic split, input logic [1:0] req);
      return split ? req : 2'b00;
   endfunction

   task automatic split_write(input int ch, input logic [2:0] a, input logic [7:0] d);
      addr = a; data_in = d; tick(1);
      if (ch == 0) sel0_n = 1'b0; else sel1_n = 1'b0;
      tick(3); wr_n = 1'b0; tick(4); wr_n = 1'b1; tick(4);
      sel0_n = 1'b1; sel1_n = 1'b1; tick(3);
      model[ch][a] = d;
   endtask

   task automatic split_read(input int ch, input logic [2:0] a, input string req);
      addr = a; tick(1);
      if (ch == 0) sel0_n = 1'b0; else sel1_n = 1'b0;
      rd_n = 1'b0; tick(4);
      chk(data_oe === 1'b1, req, "split read drive", data_oe, 1);
      chk(data_out === model[ch][a], req, "split read data", data_out, model[ch][a]);
      rd_n = 1'b1; sel0_n = 1'b1; sel1_n = 1'b1; tick(4);
      chk(data_oe === 1'b0, req, "split read release", data_oe, 0);
   endtask

   task automatic comb_write(input int ch, input logic [2:0] a, input logic [7:0] d);
      addr = a; data_in = d; sel1_n = ch[0]; wr_n = 1'b0; tick(3);
      sel0_n = 1'b0; tick(4); sel0_n = 1'b1; tick(4);
      wr_n = 1'b1; sel1_n = 1'b1; tick(2);
      model[ch][a] = d;
   endtask

   task automatic comb_read(input int ch, input logic [2:0] a, input string req);
      addr = a; sel1_n = ch[0]; wr_n = 1'b1; rd_n = 1'($urandom); tick(2);
      sel0_n = 1'b0; tick(4);
      chk(data_oe === 1'b1, req, "combined read drive", data_oe, 1);
      chk(data_out === model[ch][a], req, "combined read data", data_out, model[ch][a]);
      rd_n = ~rd_n; tick(3);
      chk(data_out === model[ch][a], req, "read strobe ignored", data_out, model[ch][a]);
      sel0_n = 1'b1; rd_n = 1'b1; sel1_n = 1'b1; tick(4);
      chk(data_oe === 1'b0, req, "combined read release", data_oe, 0);
   endtask

   task automatic irq_check(input string req);
      for (int v = 0; v < 4; v++) begin
         irq_req = 2'(v); tick(1);
         chk(irq_oe === exp_oe(mode_split, irq_req), req, "irq enable",
             irq_oe, exp_oe(mode_split, irq_req));
         if (!mode_split || irq_oe[1])
            chk(irq_o[1] === exp_o(mode_split, irq_req)[1], req, "irq1 level",
                irq_o[1], exp_o(mode_split, irq_req)[1]);
         if (irq_oe[0])
            chk(irq_o[0] === exp_o(mode_split, irq_req)[0], req, "irq0 level",
                irq_o[0], exp_o(mode_split, irq_req)[0]);
         chk(op2_n === ~{model[1][4][3], model[0][4][3]}, req, "op2 level",
             op2_n, ~{model[1][4][3], model[0][4][3]});
      end
      irq_req = '0;
   endtask

   initial begin
      void'($urandom(32'd2024));
      for (int c = 0; c < 2; c++)
         for (int a = 0; a < 8; a++) model[c][a] = '0;
      tick(3); rst_n = 1'b1; tick(3);

      // R1: reset state
      chk(data_oe === 1'b0, "R1", "reset bus drive", data_oe, 0);
      chk(irq_oe === 2'b00, "R1", "reset irq enable", irq_oe, 0);
      chk(op2_n === 2'b11, "R1", "reset op2", op2_n, 3);
      for (int c = 0; c < 2; c++)
         for (int a = 0; a < 8; a++) split_read(c, 3'(a), "R1");

      // R2 R3 R9: split-style random traffic
      for (int i = 0; i < 40; i++) begin
         int ch;
         logic [2:0] a;
         ch = int'($urandom % 2);
         a  = 3'($urandom);
         if ($urandom % 2) split_write(ch, a, 8'($urandom));
         else              split_read(ch, a, "R3");
      end
      for (int c = 0; c < 2; c++)
         for (int a = 0; a < 8; a++) split_read(c, 3'(a), "R9");

      // R4: no select, write and read ignored
      addr = 3'd5; data_in = ~model[0][5]; tick(2);
      wr_n = 1'b0; tick(4); wr_n = 1'b1; tick(4);
      rd_n = 1'b0; tick(4);
      chk(data_oe === 1'b0, "R4", "unselected read drive", data_oe, 0);
      rd_n = 1'b1; tick(3);
      split_read(0, 3'd5, "R4");
      split_read(1, 3'd5, "R4");

      // R7: split interrupts under each gate combination
      split_write(0, 3'd4, 8'h08); split_write(1, 3'd4, 8'h00); irq_check("R7");
      split_write(0, 3'd4, 8'hF7); split_write(1, 3'd4, 8'h0F); irq_check("R7");
      split_write(0, 3'd4, 8'h00); split_write(1, 3'd4, 8'h00); irq_check("R7");

      // R5 R6: combined-style traffic
      mode_split = 1'b0; tick(4);
      comb_write(0, 3'd0, 8'hA5); comb_read(0, 3'd0, "R5");
      comb_write(1, 3'd7, 8'h3C); comb_read(1, 3'd7, "R5");
      comb_read(0, 3'd7, "R5");
      for (int i = 0; i < 30; i++) begin
         int ch;
         logic [2:0] a;
         ch = int'($urandom % 2);
         a  = 3'($urandom);
         if ($urandom % 2) comb_write(ch, a, 8'($urandom));
         else              comb_read(ch, a, "R6");
      end
      for (int c = 0; c < 2; c++)
         for (int a = 0; a < 8; a++) comb_read(c, 3'(a), "R9");

      // R8: combined interrupt, with and without the split gate bits set
      comb_write(0, 3'd4, 8'h00); comb_write(1, 3'd4, 8'h00); irq_check("R8");
      comb_write(0, 3'd4, 8'h08); comb_write(1, 3'd4, 8'h08); irq_check("R8");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule